// File: doc/BRIEF.md
# Serial 8-Point Inverse Cosine Transform Stage

This block takes a stream of transform coefficients, one per clock, groups them into vectors of eight, and reconstructs eight samples per vector. Each output is a weighted sum of the eight coefficients. The weights are signed fixed-point cosine constants. The stage sustains one sample in and one sample out on every clock, with no stall. It can therefore serve as the row pass or the column pass of a separable two-dimensional transform, with a transpose buffer between the two passes.

An input strobe marks each valid coefficient. An optional start marker forces the coefficient that carries it into slot 0 of a fresh vector. On the output side, a valid strobe accompanies each sample and an end marker flags sample 7. The parameters set the input width, the output width and the number of fraction bits in the cosine constants. The fraction bits trade reconstruction accuracy against multiplier area.

Top module: `idct8_stage`

## Requirements
- R1: A synchronous active-high reset holds `outValid` and `outLast` at 0 and discards any partially collected vector. The first valid coefficient after reset lands in slot 0.
- R2: Output n equals floor((S + 2^(F-1)) / 2^F), where F is `FRAC_W` and S = sum over k of T(n,k)·X(k). The constant T(n,k) is round-half-away-from-zero of (c(k)/2)·cos((2n+1)kπ/16)·2^F, with c(0)=1/√2 and c(k)=1 otherwise.
- R3: A result above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit instead of wrapping.
- R4: Suppose the coefficient in slot 7 of a vector is captured at rising edge e. Then output sample n is presented after edge e+3+n, for n = 0..7, in order.
- R5: `outValid` stays high for eight consecutive cycles per vector. `outLast` is high only together with sample 7.
- R6: Vectors supplied back to back, one coefficient per clock, produce output back to back with no idle cycle and no lost vector.
- R7: Cycles with `inValid` low between the coefficients of a vector do not break the vector. Collection resumes at the next slot.
- R8: A coefficient with `inFirst` high goes to slot 0 and abandons any partial vector, which produces no output.
- R9: `inData` and `inFirst` are ignored while `inValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Coefficient strobe |
| inFirst | input | 1 | Coefficient is slot 0 of a new vector |
| inData | input | IN_W | Signed coefficient |
| outValid | output | 1 | Output sample strobe |
| outLast | output | 1 | Output sample is index 7 |
| outData | output | OUT_W | Signed reconstructed sample |

## Verification
On every cycle, the assertions check the framing of the output: the end marker never appears without valid, a burst has no hole before its end marker, and the end marker follows the last computed row two cycles later. They also check that a new vector is never loaded while an earlier one is still being evaluated, except at its final row. The bench scoreboard alone covers the numerical results, the rounding, the clamping and the exact arrival cycle. It also covers the stimulus scenarios: input gaps, start-marker resynchronisation and reset in mid-vector.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

  localparam int VEC_LEN = 8;
  localparam int IDX_W   = 3;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] slot;
    logic             loadHold;
    logic             compute;
    logic [IDX_W-1:0] row;
    logic             lastRow;
  } idctStrobes_t;

  function automatic real cosEighth(input int j);
    case (j)
      0:       return 1.0;
      1:       return 0.98078528040323043;
      2:       return 0.92387953251128674;
      3:       return 0.83146961230254524;
      4:       return 0.70710678118654752;
      5:       return 0.55557023301960218;
      6:       return 0.38268343236508977;
      7:       return 0.19509032201612826;
      default: return 0.0;
    endcase
  endfunction

  // Weight for output n, coefficient k, scaled by 2^frac and rounded.
  function automatic int coefVal(input int n, input int k, input int frac);
    int  m;
    real c;
    real v;
    real scale;
    m = ((2 * n + 1) * k) % 32;
    if (m > 16) m = 32 - m;
    if (m > 8) c = -cosEighth(16 - m);
    else       c = cosEighth(m);
    scale = 1.0;
    for (int i = 0; i < frac; i++) scale = scale * 2.0;
    v = c * scale * ((k == 0) ? 0.35355339059327376 : 0.5);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

endpackage

// File: rtl/idct8_ctrl.sv
module idct8_ctrl
  import idct8_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inFirst,
  output idctStrobes_t strb
);

  logic             inRegValid;
  logic             inRegFirst;
  logic [IDX_W-1:0] slotCnt;
  logic [IDX_W-1:0] effIdx;
  logic             runActive;
  logic [IDX_W-1:0] runIdx;
  logic             loadNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      inRegValid <= 1'b0;
      inRegFirst <= 1'b0;
    end else begin
      inRegValid <= inValid;
      inRegFirst <= inValid & inFirst;
    end
  end

  assign effIdx  = inRegFirst ? '0 : slotCnt;
  assign loadNow = inRegValid && (effIdx == IDX_W'(VEC_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) slotCnt <= '0;
    else if (inRegValid) slotCnt <= effIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runActive <= 1'b0;
      runIdx    <= '0;
    end else if (loadNow) begin
      runActive <= 1'b1;
      runIdx    <= '0;
    end else if (runActive) begin
      runIdx <= runIdx + 1'b1;
      if (runIdx == IDX_W'(VEC_LEN - 1)) runActive <= 1'b0;
    end
  end

  always_comb begin
    strb.capture  = inRegValid;
    strb.slot     = effIdx;
    strb.loadHold = loadNow;
    strb.compute  = runActive;
    strb.row      = runIdx;
    strb.lastRow  = (runIdx == IDX_W'(VEC_LEN - 1));
  end

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (loadNow && runActive) |-> (runIdx == IDX_W'(VEC_LEN - 1)));

endmodule

// File: rtl/idct8_datapath.sv
module idct8_datapath
  import idct8_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 10,
  parameter int FRAC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  inData,
  input  idctStrobes_t            strb,
  output logic                    outValid,
  output logic                    outLast,
  output logic signed [OUT_W-1:0] outData
);

  localparam int COEF_W = FRAC_W + 1;
  localparam int ACC_W  = IN_W + COEF_W + 3;
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] OUT_MAX = (ACC_W'(1) <<< (OUT_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] OUT_MIN = -(ACC_W'(1) <<< (OUT_W - 1));

  logic signed [IN_W-1:0]   inReg;
  logic signed [IN_W-1:0]   collect [VEC_LEN-1];
  logic signed [IN_W-1:0]   hold    [VEC_LEN];
  logic signed [COEF_W-1:0] coefRom [VEC_LEN][VEC_LEN];
  logic signed [COEF_W-1:0] rowCoef [VEC_LEN];
  logic signed [ACC_W-1:0]  dotSum;
  logic signed [ACC_W-1:0]  sumReg;
  logic                     sumValid;
  logic                     sumLast;
  logic signed [ACC_W-1:0]  rounded;
  logic signed [OUT_W-1:0]  clamped;

  for (genvar n = 0; n < VEC_LEN; n++) begin : g_row
    for (genvar k = 0; k < VEC_LEN; k++) begin : g_col
      assign coefRom[n][k] = COEF_W'(coefVal(n, k, FRAC_W));
    end
  end

  always_ff @(posedge clk) inReg <= inData;

  for (genvar s = 0; s < VEC_LEN - 1; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.capture && strb.slot == IDX_W'(s)) collect[s] <= inReg;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.loadHold) begin
      for (int s = 0; s < VEC_LEN - 1; s++) hold[s] <= collect[s];
      hold[VEC_LEN-1] <= inReg;
    end
  end

  always_comb begin
    for (int k = 0; k < VEC_LEN; k++) rowCoef[k] = coefRom[strb.row][k];
    dotSum = '0;
    for (int k = 0; k < VEC_LEN; k++)
      dotSum = dotSum + ACC_W'(hold[k]) * ACC_W'(rowCoef[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumValid <= 1'b0;
      sumLast  <= 1'b0;
    end else begin
      sumValid <= strb.compute;
      sumLast  <= strb.compute & strb.lastRow;
    end
    sumReg <= dotSum;
  end

  always_comb begin
    rounded = (sumReg + HALF) >>> FRAC_W;
    if (rounded > OUT_MAX)      clamped = OUT_MAX[OUT_W-1:0];
    else if (rounded < OUT_MIN) clamped = OUT_MIN[OUT_W-1:0];
    else                        clamped = rounded[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= sumValid;
      outLast  <= sumLast;
      outData  <= sumValid ? clamped : '0;
    end
  end

  // R5
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

  // R5
  burst_gapless_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outLast) |=> outValid);

  // R4
  last_row_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.compute && strb.lastRow) |=> ##1 outLast);

endmodule

// File: rtl/idct8_stage.sv
module idct8_stage
  import idct8_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 10,
  parameter int FRAC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic                    inFirst,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic                    outLast,
  output logic signed [OUT_W-1:0] outData
);

  idctStrobes_t strb;

  idct8_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inFirst (inFirst),
    .strb    (strb)
  );

  idct8_datapath #(
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .FRAC_W (FRAC_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inData   (inData),
    .strb     (strb),
    .outValid (outValid),
    .outLast  (outLast),
    .outData  (outData)
  );

endmodule

// File: tb/idct8_stage_tb.sv
module idct8_stage_tb;

  localparam int IN_W   = 12;
  localparam int OUT_W  = 10;
  localparam int FRAC_W = 12;

  typedef struct {
    int     data;
    bit     last;
    longint cyc;
    string  req;
  } expItem_t;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    inValid = 1'b0;
  logic                    inFirst = 1'b0;
  logic signed [IN_W-1:0]  inData = '0;
  logic                    outValid;
  logic                    outLast;
  logic signed [OUT_W-1:0] outData;

  int       checks = 0;
  int       errors = 0;
  longint   cyc = 0;
  bit       done = 0;
  expItem_t expQ[$];

  idct8_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inFirst(inFirst), .inData(inData),
    .outValid(outValid), .outLast(outLast), .outData(outData)
  );

  always #2ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int weight(input int n, input int k);
    real v;
    v = $cos(real'((2 * n + 1) * k) * 3.14159265358979324 / 16.0) * real'(1 << FRAC_W);
    v = v * ((k == 0) ? (0.5 / $sqrt(2.0)) : 0.5);
    if (v >= 0.0) return int'($floor(v + 0.5));
    else          return -int'($floor(-v + 0.5));
  endfunction

  function automatic int refSample(input int x[8], input int n);
    longint acc;
    longint r;
    acc = 0;
    for (int k = 0; k < 8; k++) acc += longint'(weight(n, k)) * longint'(x[k]);
    r = (acc + (longint'(1) << (FRAC_W - 1))) >>> FRAC_W;
    if (r > (1 << (OUT_W - 1)) - 1) r = (1 << (OUT_W - 1)) - 1;
    if (r < -(1 << (OUT_W - 1)))    r = -(1 << (OUT_W - 1));
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
      inFirst = 1'b1;
      inData  = 12'sh5A5;
    end
  endtask

  // Drives one vector; gapAt >= 0 inserts an invalid cycle after that slot.
  task automatic sendVec(input int x[8], input bit useFirst, input int gapAt, input string req);
    longint cap7;
    cap7 = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      inValid = 1'b1;
      inFirst = useFirst && (j == 0);
      inData  = IN_W'(x[j]);
      if (j == 7) cap7 = cyc + 1;
      if (j == gapAt) begin
        @(negedge clk);
        inValid = 1'b0;
        inFirst = 1'b1;
        inData  = 12'sh7FF;
      end
    end
    for (int n = 0; n < 8; n++) begin
      expItem_t it;
      it.data = refSample(x, n);
      it.last = (n == 7);
      it.cyc  = cap7 + 3 + n;
      it.req  = req;
      expQ.push_back(it);
    end
  endtask

  task automatic sendPartial(input int cnt, input bit useFirst);
    for (int j = 0; j < cnt; j++) begin
      @(negedge clk);
      inValid = 1'b1;
      inFirst = useFirst && (j == 0);
      inData  = IN_W'(300 + j);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected output", longint'(outData), 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(outData == OUT_W'(it.data), it.req, longint'(outData), it.data);
        check(outLast == it.last, {it.req, "/R5 last"}, outLast, it.last);
        check(cyc == it.cyc, {it.req, "/R4 cycle"}, cyc, it.cyc);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int v[8];
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 valid in reset", outValid, 0);
    check(outLast == 1'b0, "R1 last in reset", outLast, 0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R2 R4 R5: impulses at each coefficient position
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 8; i++) v[i] = (i == k) ? ((k % 2 == 0) ? 1000 : -1000) : 0;
      sendVec(v, 1'b1, -1, "R2 impulse");
      idle(12);
    end

    // R3: clamping at both limits
    for (int i = 0; i < 8; i++) v[i] = (i == 0) ? 2047 : 0;
    sendVec(v, 1'b1, -1, "R3 high clamp");
    for (int i = 0; i < 8; i++) v[i] = (i == 0) ? -2048 : 0;
    sendVec(v, 1'b1, -1, "R3 low clamp");
    idle(12);

    // R6: back-to-back random vectors, no start marker
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 8; i++) v[i] = int'($urandom_range(0, 1023)) - 512;
      sendVec(v, 1'b0, -1, "R6 back-to-back");
    end
    idle(12);

    // R7 R9: gap with garbage in the middle of a vector
    for (int i = 0; i < 8; i++) v[i] = 100 * i - 350;
    sendVec(v, 1'b1, 3, "R7 gap/R9 ignored");
    idle(12);

    // R8: partial vector abandoned by a new start marker
    sendPartial(5, 1'b1);
    for (int i = 0; i < 8; i++) v[i] = (i == 1) ? 800 : 40;
    sendVec(v, 1'b1, -1, "R8 resync");
    idle(14);

    // R1: reset in mid-vector discards the partial vector
    sendPartial(3, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid during reset", outValid, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) v[i] = 600 - 150 * i;
    sendVec(v, 1'b0, -1, "R1 after reset");
    idle(14);

    check(expQ.size() == 0, "R6 all outputs seen", expQ.size(), 0);
    finishRun();
  end

endmodule